// File: doc/BRIEF.md
# Taken-Branch Target Cache with Recovery Address Store

This block predicts control flow for an instruction fetch unit. It holds a small, fully associative set of entries. Each entry pairs the address of a branch that was seen to jump with the address it jumped to. The fetch address is compared against every entry in the same cycle. A match predicts a taken branch and returns the stored target as the next fetch address. No match predicts straight-line flow, so the next fetch address is the current one plus the instruction size. Only the presence of an entry carries history, which makes this a one-bit scheme.

When the front end speculates past a branch, it registers the branch in a numbered slot along with its guess. The block keeps the address of the path that was not chosen. For a taken guess that is the fall-through address. For a not-taken guess it is the precomputed target. When the branch resolves, the block does three things:
- a taken branch with no entry is installed;
- a taken branch that already has an entry gets its target refreshed;
- a not-taken branch that has an entry is removed.

If the outcome differs from the guess held in the slot, the block raises a one-cycle flush and drives the saved address as the redirect. The speculation and resolution inputs are single-cycle valid strobes with no ready. The block accepts one of each every cycle and never applies back-pressure.

Top module: `branch_target_cache`

## Requirements
- R1: After reset no entry is valid and no slot is live, so every lookup misses and `flush` is 0.
- R2: When `fetch_pc` equals the branch address of a valid entry, `pred_taken` is 1 and `pred_next_pc` equals that entry's target in the same cycle, with no clock edge in between.
- R3: When `fetch_pc` matches no valid entry, `pred_taken` is 0 and `pred_next_pc` equals `fetch_pc` + 4.
- R4: A resolution with `res_taken`=1 whose `res_pc` matches no entry installs (`res_pc`, `res_target`). A lookup of `res_pc` hits from the next cycle on.
- R5: A resolution with `res_taken`=0 removes the entry matching `res_pc`, if there is one. If there is none, the cache is left unchanged and nothing is installed.
- R6: A taken resolution whose `res_pc` already has an entry overwrites that entry's target and creates no second entry.
- R7: Installation uses the lowest-numbered invalid entry. When all 8 entries are valid, it uses a round-robin pointer that starts at entry 0 after reset and advances by one, with wrap, on each installation into a full cache.
- R8: `spec_valid` stores the guess in slot `spec_tag` and saves an alternate address there. The alternate is `spec_pc` + 4 when `spec_guess_taken`=1, and `spec_target` when it is 0.
- R9: A resolution on a live slot whose `res_taken` differs from the stored guess sets `flush` to 1 for exactly the following cycle, with `redirect_pc` equal to the slot's saved alternate. A matching outcome gives no flush.
- R10: Resolving a slot that is not live produces no flush, although the cache update still applies. Every resolution frees its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Current fetch address to look up |
| pred_taken | output | 1 | Lookup hit: predicted taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| spec_valid | input | 1 | Register a speculated branch this cycle |
| spec_tag | input | 2 | Slot number for the speculated branch |
| spec_pc | input | 32 | Address of the speculated branch |
| spec_guess_taken | input | 1 | Direction the front end chose |
| spec_target | input | 32 | Precomputed branch target |
| res_valid | input | 1 | A branch outcome is presented this cycle |
| res_tag | input | 2 | Slot number of the resolving branch |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_target | input | 32 | Actual target of the branch |
| flush | output | 1 | One-cycle misprediction pulse |
| redirect_pc | output | 32 | Recovery fetch address, valid while flush is 1 |

## Verification
Directed cases come first. A run of nine distinct taken branches fills the cache and forces the first round-robin eviction, and an invalidation then shows that the hole it leaves is refilled ahead of the pointer. A refresh of an existing entry shows that updating a target differs from installing a new entry. Random traffic then draws from twelve branch addresses, so hits, misses, evictions and removals interleave. Guesses are random, so both recovery directions occur: a taken guess that should flush to the fall-through address, and a not-taken guess that should flush to the target. The traffic also includes resolutions on slots that were never registered.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_INSTALL = 2'd1,
    UPD_REFRESH = 2'd2,
    UPD_DROP    = 2'd3
  } upd_act_e;

  function automatic upd_act_e decide(input logic vld, input logic taken, input logic hit);
    if (!vld) return UPD_NONE;
    if (taken) return hit ? UPD_REFRESH : UPD_INSTALL;
    return hit ? UPD_DROP : UPD_NONE;
  endfunction
endpackage

// File: rtl/btc_match.sv
module btc_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [ADDR_W-1:0] ent_pc [ENTRIES],
  input  logic [ADDR_W-1:0] key,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_pc[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
  assign hit = |eq;

  // insertion never creates two entries for one address (R6)
  p_no_dup_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(eq));
endmodule

// File: rtl/btc_victim.sv
module btc_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic               alloc,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (alloc && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // pointer moves only on an install into a full set (R7)
  p_rr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(alloc) && !$past(any_free)) |-> $stable(rr_q));
endmodule

// File: rtl/btc_altpath.sv
module btc_altpath #(
  parameter int SLOTS       = 4,
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4,
  localparam int TAG_W      = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_valid,
  input  logic [TAG_W-1:0]  spec_tag,
  input  logic [ADDR_W-1:0] spec_pc,
  input  logic              spec_guess_taken,
  input  logic [ADDR_W-1:0] spec_target,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic              res_taken,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);
  logic [SLOTS-1:0] live_q;
  logic [SLOTS-1:0] guess_q;
  logic [ADDR_W-1:0] alt_q [SLOTS];
  logic              mispredict;

  assign mispredict = res_valid && live_q[res_tag] && (res_taken != guess_q[res_tag]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q      <= '0;
      guess_q     <= '0;
      flush       <= 1'b0;
      redirect_pc <= '0;
      for (int s = 0; s < SLOTS; s++) alt_q[s] <= '0;
    end else begin
      flush <= mispredict;
      if (mispredict) redirect_pc <= alt_q[res_tag];
      if (res_valid) live_q[res_tag] <= 1'b0;
      if (spec_valid) begin
        live_q[spec_tag]  <= 1'b1;
        guess_q[spec_tag] <= spec_guess_taken;
        alt_q[spec_tag]   <= spec_guess_taken ? spec_pc + ADDR_W'(INSTR_BYTES) : spec_target;
      end
    end
  end

  // a flush follows only a resolution of a live slot (R10)
  p_flush_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(res_valid));
  // a resolved slot is free afterwards unless re-registered (R10)
  p_slot_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(spec_valid && spec_tag == res_tag)) |=> !live_q[$past(res_tag)]);
  // registering marks the slot live (R8)
  p_slot_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spec_valid |=> live_q[$past(spec_tag)]);
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
  parameter int ENTRIES     = 8,
  parameter int SLOTS       = 4,
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int TAG_W      = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              spec_valid,
  input  logic [TAG_W-1:0]  spec_tag,
  input  logic [ADDR_W-1:0] spec_pc,
  input  logic              spec_guess_taken,
  input  logic [ADDR_W-1:0] spec_target,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);
  import btc_pkg::*;

  logic [ENTRIES-1:0] ent_valid;
  logic [ADDR_W-1:0]  ent_pc  [ENTRIES];
  logic [ADDR_W-1:0]  ent_tgt [ENTRIES];

  logic             f_hit, r_hit;
  logic [IDX_W-1:0] f_idx, r_idx, vic;
  upd_act_e         act;

  btc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fetch_match (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_pc(ent_pc),
    .key(fetch_pc), .hit(f_hit), .idx(f_idx));

  btc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_res_match (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_pc(ent_pc),
    .key(res_pc), .hit(r_hit), .idx(r_idx));

  assign act = decide(res_valid, res_taken, r_hit);

  btc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid),
    .alloc(act == UPD_INSTALL), .victim(vic));

  assign pred_taken   = f_hit;
  assign pred_next_pc = f_hit ? ent_tgt[f_idx] : fetch_pc + ADDR_W'(INSTR_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        ent_pc[e]  <= '0;
        ent_tgt[e] <= '0;
      end
    end else begin
      unique case (act)
        UPD_INSTALL: begin
          ent_valid[vic] <= 1'b1;
          ent_pc[vic]    <= res_pc;
          ent_tgt[vic]   <= res_target;
        end
        UPD_REFRESH: ent_tgt[r_idx] <= res_target;
        UPD_DROP:    ent_valid[r_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  btc_altpath #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_alt (
    .clk(clk), .rst_n(rst_n),
    .spec_valid(spec_valid), .spec_tag(spec_tag), .spec_pc(spec_pc),
    .spec_guess_taken(spec_guess_taken), .spec_target(spec_target),
    .res_valid(res_valid), .res_tag(res_tag), .res_taken(res_taken),
    .flush(flush), .redirect_pc(redirect_pc));

  // installed branch is present in the chosen entry next cycle (R4)
  p_install_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == UPD_INSTALL) |=> ent_valid[$past(vic)] && ent_pc[$past(vic)] == $past(res_pc));
  // not-taken outcome clears the matching entry (R5)
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == UPD_DROP) |=> !ent_valid[$past(r_idx)]);
  // refresh keeps the entry and takes the new target (R6)
  p_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == UPD_REFRESH) |=> ent_valid[$past(r_idx)] && ent_tgt[$past(r_idx)] == $past(res_target));
  // a not-taken outcome never adds a valid entry (R5)
  p_no_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |=> $countones(ent_valid) <= $countones($past(ent_valid)));
endmodule

// File: tb/branch_target_cache_bench.sv
module branch_target_cache_bench;
  localparam int N = 8;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic [31:0] pred_next_pc;
  logic        spec_valid = 1'b0;
  logic [1:0]  spec_tag = '0;
  logic [31:0] spec_pc = '0;
  logic        spec_guess_taken = 1'b0;
  logic [31:0] spec_target = '0;
  logic        res_valid = 1'b0;
  logic [1:0]  res_tag = '0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic        flush;
  logic [31:0] redirect_pc;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_target_cache u_branch_target_cache (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_next_pc(pred_next_pc), .spec_valid(spec_valid), .spec_tag(spec_tag),
    .spec_pc(spec_pc), .spec_guess_taken(spec_guess_taken), .spec_target(spec_target),
    .res_valid(res_valid), .res_tag(res_tag), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .flush(flush), .redirect_pc(redirect_pc));

  // reference state
  bit          m_v [N];
  logic [31:0] m_pc [N];
  logic [31:0] m_tg [N];
  int          m_rr;
  bit          s_live [S];
  bit          s_guess [S];
  logic [31:0] s_alt [S];

  function automatic int m_find(input logic [31:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_pc[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a);
    int k;
    fetch_pc = a;
    #2;
    k = m_find(a);
    if (k >= 0) begin
      chk("R2 taken", 32'(pred_taken), 32'd1);
      chk("R2 target", pred_next_pc, m_tg[k]);
    end else begin
      chk("R3 taken", 32'(pred_taken), 32'd0);
      chk("R3 next", pred_next_pc, a + 32'd4);
    end
  endtask

  // one cycle: drive at negedge, model at edge, check registered outputs after
  task automatic step(input logic [31:0] fpc,
                      input bit sv, input int stag, input logic [31:0] spc, input bit sg, input logic [31:0] stg,
                      input bit rv, input int rtag, input logic [31:0] rpc, input bit rt, input logic [31:0] rtg);
    bit ef; logic [31:0] er; int k; int v;
    spec_valid = sv; spec_tag = 2'(stag); spec_pc = spc; spec_guess_taken = sg; spec_target = stg;
    res_valid = rv; res_tag = 2'(rtag); res_pc = rpc; res_taken = rt; res_target = rtg;
    look(fpc);
    @(posedge clk);
    ef = rv && s_live[rtag] && (rt != s_guess[rtag]);
    er = s_alt[rtag];
    if (rv) begin
      k = m_find(rpc);
      if (rt && k >= 0) m_tg[k] = rtg;
      else if (rt) begin
        v = m_victim();
        if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % N; end
        m_v[v] = 1; m_pc[v] = rpc; m_tg[v] = rtg;
      end else if (k >= 0) m_v[k] = 0;
      s_live[rtag] = 0;
    end
    if (sv) begin
      s_live[stag] = 1; s_guess[stag] = sg;
      s_alt[stag] = sg ? spc + 32'd4 : stg;
    end
    @(negedge clk);
    spec_valid = 0; res_valid = 0;
    chk("R9 flush", 32'(flush), 32'(ef));
    if (ef) chk("R9 redirect", redirect_pc, er);
  endtask

  task automatic resolve(input logic [31:0] pc, input bit t, input logic [31:0] tg);
    step(32'h0, 0, 0, 0, 0, 0, 1, 3, pc, t, tg);
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ok;
    void'($urandom(32'd1234));
    m_rr = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    for (int i = 0; i < S; i++) begin s_live[i] = 0; s_guess[i] = 0; s_alt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 flush", 32'(flush), 32'd0);
    look(32'h2000);
    chk("R1 miss", 32'(pred_taken), 32'd0);
    // R4/R7: fill nine, first eviction hits entry 0
    for (int i = 0; i < 9; i++) resolve(32'h2000 + 32'(i * 4), 1, 32'h9000 + 32'(i * 16));
    look(32'h2000);
    chk("R7 evicted", 32'(pred_taken), 32'd0);
    look(32'h2020);
    chk("R4 installed", pred_next_pc, 32'h9080);
    // R5: drop then refill the hole before the pointer
    resolve(32'h2010, 0, 0);
    look(32'h2010);
    chk("R5 dropped", 32'(pred_taken), 32'd0);
    resolve(32'h3000, 0, 0);
    look(32'h3000);
    chk("R5 not inserted", 32'(pred_taken), 32'd0);
    resolve(32'h2100, 1, 32'hA000);
    look(32'h2004);
    chk("R7 hole reused", 32'(pred_taken), 32'd1);
    // R6: refresh target
    resolve(32'h2008, 1, 32'hBEE0);
    look(32'h2008);
    chk("R6 refresh", pred_next_pc, 32'hBEE0);
    // R8/R9 both recovery directions
    step(0, 1, 0, 32'h4000, 1, 32'h7000, 0, 0, 0, 0, 0);
    step(0, 1, 1, 32'h4100, 0, 32'h7700, 1, 0, 32'h4000, 0, 0);
    chk("R8 fallthrough alt", redirect_pc, 32'h4004);
    step(0, 0, 0, 0, 0, 0, 1, 1, 32'h4100, 1, 32'h7700);
    chk("R8 target alt", redirect_pc, 32'h7700);
    // R10: dead slot resolution
    step(0, 0, 0, 0, 0, 0, 1, 2, 32'h4200, 0, 0);
    chk("R10 no flush", 32'(flush), 32'd0);
    // random traffic
    for (int it = 0; it < 4000; it++) begin
      int st, rtg_i;
      bit sv, rv;
      st = int'($urandom % S);
      rtg_i = int'($urandom % S);
      sv = ($urandom % 2) == 1;
      rv = ($urandom % 3) != 0;
      if (sv && rv && st == rtg_i) sv = 0;
      step(32'h5000 + 32'(($urandom % 12) * 4),
           sv, st, 32'h5000 + 32'(($urandom % 12) * 4), ($urandom % 2) == 1, 32'h8000 + 32'(($urandom % 64) * 4),
           rv, rtg_i, 32'h5000 + 32'(($urandom % 12) * 4), ($urandom % 3) != 0, 32'h8000 + 32'(($urandom % 64) * 4));
    end
    ok = 1;
    done = ok == 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule